// File: doc/BRIEF.md
# SPI Host Shift Engine

This block is the serial core of a SPI host. It holds one 32-bit configuration word that sets the clock polarity, clock phase, serial clock divisor and slave-select behaviour. When the engine is running it takes 8-bit words from a show-ahead transmit queue. For each word it sends one out and takes one in at the same time, and it hands each received byte to a receive queue with a one-cycle strobe. The queues and any interrupt logic are separate blocks. A mode-fault condition from a competing host arrives as a single input pin.

Software writes the configuration word and drives a level `engineEn` that gates the whole engine. A new clock polarity or phase does not reach the serial logic when the word is written. It takes effect only on the next rising edge of `engineEn`, so the idle clock level never moves while the engine stays enabled. A word can start as soon as the queue offers one. In manual-start mode a word waits until software writes the start bit, and that one start drains the queue. Slave-select is either driven by the engine around each word or held by software. It is either a one-hot active-low pattern or a binary code for an external decoder.

Top module: `spiq_host`

## Requirements
- R1: After reset the configuration reads 0x00007C09: host bit 0 set, divisor field bits 5:3 = 1, slave-select field bits 13:10 = 0xF, manual-select bit 14 set, all other bits 0. After reset `ssN` is 4'hF, `sclk` is 0 and `busy` is 0.
- R2: With divisor field value d, each `sclk` half period lasts 2^d reference cycles, so the full period is 2<<d. A value of 0 acts as 1.
- R3: Each word is a full-duplex 8-bit exchange, sent and received MSB first. `txPop` pulses only while `txValid` is high, in the cycle that consumes `txData`. The received byte appears on `rxData` during a single-cycle `rxPush`.
- R4: With phase bit 2 clear, the first bit is on `mosi` before the first `sclk` edge, `miso` is sampled on leading edges and `mosi` changes on trailing edges. With phase bit 2 set, `mosi` changes on leading edges and `miso` is sampled on trailing edges. The leading edge is the one that leaves the idle level.
- R5: The idle `sclk` level equals the polarity (bit 1) that was active at the last rising edge of `engineEn`. Writing new polarity or phase bits while enabled changes neither the idle level nor the timing until `engineEn` is toggled.
- R6: With manual-select bit 14 clear, `ssN` shows the selected pattern only while a word is in progress and is 4'hF otherwise.
- R7: With bit 14 set, `ssN` follows the select field continuously while the engine runs.
- R8: With decode bit 9 clear, only the lowest-numbered 0 bit of the field is driven low: field 4'b0101 gives `ssN` 4'b1101. With bit 9 set, the field is driven unchanged as a binary code: 4'b0101 gives 4'b0101.
- R9: With manual-start bit 15 clear, a word starts whenever the engine runs, it is idle and `txValid` is high.
- R10: With bit 15 set, no word starts until a configuration write carries bits 15 and 16 both set. The engine then sends words until the queue is empty, and the arm is cleared. Bit 16 always reads 0.
- R11: The engine runs only when `engineEn` and host bit 0 are both high. Otherwise no word starts, a word in progress is dropped without `rxPush`, and `ssN` is 4'hF.
- R12: While `modeFault` is high, no word starts and a word in progress is dropped without `rxPush`. Normal operation resumes when it falls.
- R13: `busy` rises in the cycle after `txPop` and stays high up to and including the `rxPush` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| engineEn | input | 1 | Global engine enable; its rising edge latches polarity and phase |
| cfgWr | input | 1 | Configuration write strobe |
| cfgWdata | input | 32 | Configuration write data |
| cfgRdata | output | 32 | Configuration read value |
| txValid | input | 1 | Transmit queue holds a word |
| txData | input | 8 | Head word of the transmit queue |
| txPop | output | 1 | Consume the head transmit word |
| rxData | output | 8 | Received byte |
| rxPush | output | 1 | Received byte valid, one cycle |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssN | output | 4 | Slave-select lines or decoder code |
| modeFault | input | 1 | Mode fault from another host |
| busy | output | 1 | Word in progress |

## Verification
The assertions hold on every cycle for these rules: the pop/valid relation, the fact that a push lies inside `busy`, the start of `busy` after a pop, at most one low line in one-hot mode, the all-high select and idle engine when disabled, no push during a fault, and a steady idle clock between enable edges. Only the scenarios can show the rest. They cover the bit order and the sample and drive edges in all four clock modes, the half-period length for several divisors, the delayed effect of polarity and phase, the manual-start arm and its clearing, and the dropping of a word on disable or fault. A slave model in the bench checks these against bytes it sends and captures on its own.

// File: rtl/spiq_pkg.sv
package spiq_pkg;

  // configuration word layout
  localparam int CFG_W        = 32;
  localparam int BIT_HOST     = 0;
  localparam int BIT_CPOL     = 1;
  localparam int BIT_CPHA     = 2;
  localparam int DIV_LO       = 3;
  localparam int BIT_DECODE   = 9;
  localparam int SS_LO        = 10;
  localparam int BIT_MANSS    = 14;
  localparam int BIT_MANSTART = 15;
  localparam int BIT_GO       = 16;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // take a new word from the queue
    logic driveBit;   // move next bit onto mosi
    logic sampleBit;  // shift miso into the register
    logic clkToggle;  // flip the serial clock phase
    logic abort;      // drop the word, return clock to idle
    logic push;       // hand received byte to the queue
  } shiftStrobeT;

endpackage

// File: rtl/spiq_ctrl.sv
module spiq_ctrl
  import spiq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          run,
  input  logic                          startReq,
  input  logic                          cpha,
  input  logic [(1 << DIV_W) - 2:0]     halfMax,
  output shiftStrobeT                   stb,
  output logic                          busy
);

  localparam int HALF_W    = (1 << DIV_W) - 1;
  localparam int EDGE_W    = $clog2(2 * DATA_W);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * DATA_W - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_DONE} stateT;

  stateT              state, stateNxt;
  logic [HALF_W-1:0]  halfCnt, halfQ;
  logic [EDGE_W-1:0]  edgeCnt;
  logic               edgeNow;

  assign edgeNow = (halfCnt == '0);

  always_comb begin
    stb      = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (run && startReq) begin
          stb.load = 1'b1;
          stateNxt = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (!run) begin
          stb.abort = 1'b1;
          stateNxt  = ST_IDLE;
        end else if (edgeNow) begin
          stb.clkToggle = 1'b1;
          if (edgeCnt[0] == cpha) begin
            stb.sampleBit = 1'b1;
          end else if (!(edgeCnt == LAST_EDGE && !cpha)) begin
            stb.driveBit = 1'b1;
          end
          if (edgeCnt == LAST_EDGE) stateNxt = ST_DONE;
        end
      end
      ST_DONE: begin
        stb.push = 1'b1;
        stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      halfCnt <= '0;
      halfQ   <= '0;
      edgeCnt <= '0;
    end else begin
      state <= stateNxt;
      if (stb.load) begin
        halfCnt <= halfMax;
        halfQ   <= halfMax;
        edgeCnt <= '0;
      end else if (state == ST_SHIFT && run) begin
        if (edgeNow) begin
          halfCnt <= halfQ;
          edgeCnt <= edgeCnt + 1'b1;
        end else begin
          halfCnt <= halfCnt - 1'b1;
        end
      end
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/spiq_dpath.sv
module spiq_dpath
  import spiq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SS_N   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  shiftStrobeT       stb,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [DATA_W-1:0] txData,
  input  logic              miso,
  input  logic [SS_N-1:0]   ssField,
  input  logic              decodeMode,
  input  logic              manualSs,
  input  logic              busy,
  input  logic              run,
  output logic              sclk,
  output logic              mosi,
  output logic [DATA_W-1:0] rxData,
  output logic              rxPush,
  output logic [SS_N-1:0]   ssN
);

  logic [DATA_W-1:0] shiftQ;
  logic              mosiQ;
  logic              phaseQ;
  logic [SS_N-1:0]   oneHot;
  logic [SS_N-1:0]   pattern;
  logic              found;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      mosiQ  <= 1'b0;
      phaseQ <= 1'b0;
    end else begin
      if (stb.load) begin
        shiftQ <= txData;
        if (!cpha) mosiQ <= txData[DATA_W-1];
      end
      if (stb.sampleBit) shiftQ <= {shiftQ[DATA_W-2:0], miso};
      if (stb.driveBit)  mosiQ  <= shiftQ[DATA_W-1];
      if (stb.abort)          phaseQ <= 1'b0;
      else if (stb.clkToggle) phaseQ <= ~phaseQ;
    end
  end

  // keep only the lowest-numbered low bit in one-hot mode
  always_comb begin
    oneHot = '1;
    found  = 1'b0;
    for (int i = 0; i < SS_N; i++) begin
      if (!ssField[i] && !found) begin
        oneHot[i] = 1'b0;
        found     = 1'b1;
      end
    end
  end

  assign pattern = decodeMode ? ssField : oneHot;

  always_comb begin
    if (!run)          ssN = '1;
    else if (manualSs) ssN = pattern;
    else if (busy)     ssN = pattern;
    else               ssN = '1;
  end

  assign sclk   = phaseQ ^ cpol;
  assign mosi   = mosiQ;
  assign rxData = shiftQ;
  assign rxPush = stb.push;

endmodule

// File: rtl/spiq_host.sv
module spiq_host
  import spiq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 3,
  parameter int SS_N   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              engineEn,
  input  logic              cfgWr,
  input  logic [31:0]       cfgWdata,
  output logic [31:0]       cfgRdata,
  input  logic              txValid,
  input  logic [DATA_W-1:0] txData,
  output logic              txPop,
  output logic [DATA_W-1:0] rxData,
  output logic              rxPush,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [SS_N-1:0]   ssN,
  input  logic              modeFault,
  output logic              busy
);

  localparam int HALF_W = (1 << DIV_W) - 1;

  localparam logic [CFG_W-1:0] DIV_MASK = CFG_W'(((1 << DIV_W) - 1) << DIV_LO);
  localparam logic [CFG_W-1:0] SS_MASK  = CFG_W'(((1 << SS_N) - 1) << SS_LO);
  localparam logic [CFG_W-1:0] CFG_MASK = DIV_MASK | SS_MASK
    | (CFG_W'(1) << BIT_HOST) | (CFG_W'(1) << BIT_CPOL) | (CFG_W'(1) << BIT_CPHA)
    | (CFG_W'(1) << BIT_DECODE) | (CFG_W'(1) << BIT_MANSS)
    | (CFG_W'(1) << BIT_MANSTART);
  localparam logic [CFG_W-1:0] CFG_RESET = (CFG_W'(1) << BIT_HOST)
    | (CFG_W'(1) << DIV_LO) | SS_MASK | (CFG_W'(1) << BIT_MANSS);

  logic [CFG_W-1:0]  cfgQ;
  logic              enPrev, cpolAct, cphaAct, armed, run, startReq;
  logic [DIV_W-1:0]  divRaw, divEff;
  logic [HALF_W-1:0] halfMax;
  shiftStrobeT       stb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ    <= CFG_RESET;
      enPrev  <= 1'b0;
      cpolAct <= 1'b0;
      cphaAct <= 1'b0;
      armed   <= 1'b0;
    end else begin
      if (cfgWr) cfgQ <= cfgWdata & CFG_MASK;
      enPrev <= engineEn;
      if (engineEn && !enPrev) begin
        cpolAct <= cfgQ[BIT_CPOL];
        cphaAct <= cfgQ[BIT_CPHA];
      end
      if (cfgWr && cfgWdata[BIT_MANSTART] && cfgWdata[BIT_GO]) armed <= 1'b1;
      else if (!run || (!busy && !txValid)) armed <= 1'b0;
    end
  end

  assign run      = engineEn && cfgQ[BIT_HOST] && !modeFault;
  assign startReq = txValid && (cfgQ[BIT_MANSTART] ? armed : 1'b1);
  assign divRaw   = cfgQ[DIV_LO +: DIV_W];
  assign divEff   = (divRaw == '0) ? DIV_W'(1) : divRaw;
  assign halfMax  = HALF_W'((1 << divEff) - 1);
  assign cfgRdata = cfgQ;
  assign txPop    = stb.load;

  spiq_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) ctrlI (
    .clk(clk), .rstN(rstN), .run(run), .startReq(startReq),
    .cpha(cphaAct), .halfMax(halfMax), .stb(stb), .busy(busy)
  );

  spiq_dpath #(.DATA_W(DATA_W), .SS_N(SS_N)) dpathI (
    .clk(clk), .rstN(rstN), .stb(stb), .cpol(cpolAct), .cpha(cphaAct),
    .txData(txData), .miso(miso), .ssField(cfgQ[SS_LO +: SS_N]),
    .decodeMode(cfgQ[BIT_DECODE]), .manualSs(cfgQ[BIT_MANSS]),
    .busy(busy), .run(run), .sclk(sclk), .mosi(mosi),
    .rxData(rxData), .rxPush(rxPush), .ssN(ssN)
  );

endmodule

// File: rtl/spiq_host_chk.sv
module spiq_host_chk (
  input logic        clk,
  input logic        rstN,
  input logic        engineEn,
  input logic        modeFault,
  input logic        txValid,
  input logic        txPop,
  input logic        rxPush,
  input logic        busy,
  input logic        sclk,
  input logic [3:0]  ssN,
  input logic [31:0] cfgRdata
);

  // R3
  pop_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    txPop |-> txValid);

  // R13
  push_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |-> busy);

  // R13
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(txPop));

  // R8
  onehot_ss_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRdata[9] |-> ($countones(~ssN) <= 1));

  // R11
  off_ss_chk: assert property (@(posedge clk) disable iff (!rstN)
    !engineEn |-> (ssN == 4'hF));

  // R11
  off_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!engineEn && $past(!engineEn)) |-> !busy);

  // R12
  fault_nopush_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeFault && $past(modeFault)) |-> !rxPush);

  // R5
  idle_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy) && $stable(engineEn)
      && ($past(engineEn) == $past(engineEn, 2))) |-> $stable(sclk));

endmodule

bind spiq_host spiq_host_chk chkI (.*);

// File: tb/spiq_host_test.sv
module spiq_host_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN, engineEn, cfgWr, txValid, miso, modeFault;
  logic [31:0] cfgWdata, cfgRdata;
  logic [7:0]  txData, rxData;
  logic        txPop, rxPush, sclk, mosi, busy;
  logic [3:0]  ssN;

  spiq_host uut (
    .clk(clk), .rstN(rstN), .engineEn(engineEn), .cfgWr(cfgWr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .txValid(txValid),
    .txData(txData), .txPop(txPop), .rxData(rxData), .rxPush(rxPush),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ssN(ssN),
    .modeFault(modeFault), .busy(busy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  logic [7:0] txQ[$];
  logic [7:0] slvQ[$];
  logic [7:0] expTx[$];
  logic [7:0] expRx[$];

  int         curCpha = 0;
  int         curHalf = 2;
  int         eCnt = 0;
  int         cyc = 0;
  int         lastTog = 0;
  int         pushCnt = 0;
  int         misoIdx;
  bit         halfBad = 0;
  logic [7:0] slvByte = 8'h00;
  logic [7:0] mCap = 8'h00;
  logic       prevSclk = 1'b0;
  logic       prevBusy = 1'b0;
  logic       popPending = 1'b0;
  bit         done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void refreshTx();
    txValid = (txQ.size() != 0);
    txData  = txValid ? txQ[0] : 8'h00;
  endfunction

  // slave model: presents its byte MSB first on miso
  always_comb begin
    if (curCpha != 0) misoIdx = (eCnt == 0) ? 0 : (eCnt - 1) / 2;
    else              misoIdx = eCnt / 2;
    if (misoIdx > 7) misoIdx = 7;
    miso = slvByte[7 - misoIdx];
  end

  always @(posedge clk) popPending <= txPop;

  // queue model, slave capture and scoreboard monitor
  always @(negedge clk) begin
    if (popPending && txQ.size() != 0) begin
      void'(txQ.pop_front());
      refreshTx();
    end
    if (busy && !prevBusy) begin
      eCnt    = 0;
      slvByte = (slvQ.size() != 0) ? slvQ.pop_front() : 8'h00;
      mCap    = 8'h00;
      lastTog = cyc;
      halfBad = 0;
    end
    if (busy && sclk != prevSclk) begin
      if ((eCnt % 2) == curCpha) mCap = {mCap[6:0], mosi};
      if (cyc - lastTog != curHalf) halfBad = 1;
      lastTog = cyc;
      eCnt++;
    end
    if (rxPush) begin
      pushCnt++;
      if (expRx.size() == 0) begin
        check(0, "R3", "unexpected push", rxData, 0);
      end else begin
        logic [7:0] er, et;
        er = expRx.pop_front();
        et = expTx.pop_front();
        check(rxData == er, "R3", "received byte", rxData, er);
        check(mCap == et, "R4", "byte seen by slave", mCap, et);
        check(!halfBad, "R2", "sclk half period", 1, 0);
        check(eCnt == 16, "R4", "sclk edge count", eCnt, 16);
      end
    end
    prevSclk = sclk;
    prevBusy = busy;
    cyc++;
  end

  task automatic cfgWrite(input logic [31:0] v);
    @(negedge clk);
    cfgWr = 1'b1; cfgWdata = v;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] tx, input logic [7:0] slv);
    txQ.push_back(tx);
    slvQ.push_back(slv);
    expTx.push_back(tx);
    expRx.push_back(slv);
    refreshTx();
  endtask

  task automatic toggleEn();
    @(negedge clk); engineEn = 1'b0;
    @(negedge clk); engineEn = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic waitBusy(input string req);
    int n = 0;
    while (!busy && n < 1000) begin @(negedge clk); n++; end
    check(busy, req, "word did not start", 0, 1);
  endtask

  task automatic drain(input string req);
    int n = 0;
    while (expRx.size() != 0 && n < 12000) begin @(negedge clk); n++; end
    check(expRx.size() == 0, req, "words left undelivered", expRx.size(), 0);
    @(negedge clk);
  endtask

  task automatic dropFront();
    void'(expTx.pop_front());
    void'(expRx.pop_front());
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int pc;
    rstN = 1'b0; engineEn = 1'b0; cfgWr = 1'b0; cfgWdata = '0; modeFault = 1'b0;
    refreshTx();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(cfgRdata == 32'h0000_7C09, "R1", "config reset", cfgRdata, 32'h7C09);
    check(ssN == 4'hF, "R1", "ssN reset", ssN, 4'hF);
    check(sclk == 1'b0 && busy == 1'b0, "R1", "sclk/busy reset", {sclk, busy}, 0);

    engineEn = 1'b1;
    // mode 0, d=1, engine-driven one-hot select of line 2
    cfgWrite(32'h0000_2C09);
    curCpha = 0; curHalf = 2;
    check(ssN == 4'hF, "R6", "idle select", ssN, 4'hF);
    sendByte(8'hA5, 8'h5A);
    sendByte(8'h3C, 8'hC3);
    waitBusy("R9");
    check(ssN == 4'b1011, "R6", "select during word", ssN, 4'b1011);
    drain("R9");
    check(ssN == 4'hF && !busy, "R6", "select after words", ssN, 4'hF);

    // mode 3, d=2: new polarity waits for the enable edge
    cfgWrite(32'h0000_2C17);
    repeat (3) @(negedge clk);
    check(sclk == 1'b0, "R5", "idle level before enable edge", sclk, 0);
    toggleEn();
    check(sclk == 1'b1, "R5", "idle level after enable edge", sclk, 1);
    curCpha = 1; curHalf = 4;
    sendByte(8'h81, 8'h7E);
    sendByte(8'h00, 8'hFF);
    drain("R4");

    // mode 1, divisor 0 acts as 1
    cfgWrite(32'h0000_2C05);
    toggleEn();
    check(sclk == 1'b0, "R5", "mode 1 idle level", sclk, 0);
    curCpha = 1; curHalf = 2;
    sendByte(8'h96, 8'h69);
    drain("R2");

    // mode 2, slowest divisor
    cfgWrite(32'h0000_2C3B);
    toggleEn();
    check(sclk == 1'b1, "R5", "mode 2 idle level", sclk, 1);
    curCpha = 0; curHalf = 128;
    sendByte(8'hC3, 8'h3C);
    drain("R2");

    // manual select and manual start, mode 0 d=1
    cfgWrite(32'h0000_DC09);
    toggleEn();
    curCpha = 0; curHalf = 2;
    check(ssN == 4'b0111, "R7", "held select while idle", ssN, 4'b0111);
    sendByte(8'h11, 8'hEE);
    sendByte(8'h22, 8'hDD);
    repeat (40) @(negedge clk);
    check(!busy && expRx.size() == 2, "R10", "no start before go", busy, 0);
    cfgWrite(32'h0001_DC09);
    check(cfgRdata == 32'h0000_DC09, "R10", "go bit reads zero", cfgRdata, 32'hDC09);
    drain("R10");
    check(ssN == 4'b0111, "R7", "held select after words", ssN, 4'b0111);
    sendByte(8'h33, 8'hCC);
    repeat (40) @(negedge clk);
    check(!busy && expRx.size() == 1, "R10", "arm cleared after drain", busy, 0);
    cfgWrite(32'h0001_DC09);
    drain("R10");

    // one-hot sanitising versus decoder code
    cfgWrite(32'h0000_5409);
    check(ssN == 4'b1101, "R8", "one-hot lowest line", ssN, 4'b1101);
    cfgWrite(32'h0000_5609);
    check(ssN == 4'b0101, "R8", "decoder code", ssN, 4'b0101);

    // drop a word by disabling the engine
    cfgWrite(32'h0000_2C19);
    curCpha = 0; curHalf = 8;
    sendByte(8'h55, 8'hAA);
    waitBusy("R11");
    repeat (20) @(negedge clk);
    pc = pushCnt;
    engineEn = 1'b0;
    repeat (2) @(negedge clk);
    check(!busy && ssN == 4'hF, "R11", "disabled mid-word", {busy, ssN}, 4'hF);
    check(pushCnt == pc, "R11", "no push after disable", pushCnt, pc);
    dropFront();
    engineEn = 1'b1;
    repeat (2) @(negedge clk);
    sendByte(8'h5A, 8'hA5);
    drain("R11");

    // mode fault drops the word and blocks starts
    sendByte(8'h0F, 8'hF0);
    waitBusy("R12");
    repeat (10) @(negedge clk);
    pc = pushCnt;
    modeFault = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && pushCnt == pc, "R12", "fault drops word", pushCnt, pc);
    dropFront();
    sendByte(8'hF0, 8'h0F);
    repeat (30) @(negedge clk);
    check(!busy && expRx.size() == 1, "R12", "no start during fault", busy, 0);
    modeFault = 1'b0;
    drain("R12");

    // host bit clear blocks starts
    cfgWrite(32'h0000_2C18);
    sendByte(8'h44, 8'hBB);
    repeat (30) @(negedge clk);
    check(!busy && ssN == 4'hF, "R11", "host bit clear", {busy, ssN}, 4'hF);
    cfgWrite(32'h0000_2C19);
    drain("R9");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule